// File: doc/BRIEF.md
# Workload-Keyed Voltage and Clock Operating Point Sequencer

This block turns a workload description into a supply-voltage and clock-frequency operating point, and then walks the hardware to that point in a safe order. A workload is given as a number of active users together with the constraint length of the channel decoder. When `wl_valid` is high the two fields are captured. The block looks up one of five operating points from a built-in table. If the point differs from the one in use, it runs a transition through a request/acknowledge handshake with the voltage regulator and a select output to the clock generator.

The clock never runs faster than the supply can carry. When performance goes up, the higher voltage is requested first, and the faster clock is selected only after a fixed settling interval counted from the regulator's acknowledge. When performance goes down, the slower clock is selected first and the lower voltage is requested afterwards. While a transition is in progress, `busy` is high. A workload that arrives during a transition is held, and the most recent one is served after the current transition completes.

Operating point codes are 0 = 433 MHz / 0.875 V, 1 = 533 MHz / 0.95 V, 2 = 667 MHz / 1.05 V, 3 = 1000 MHz / 1.3 V and 4 = 1200 MHz / 1.4 V. `vreg_code`, `clk_sel` and `op_point` all use these codes.

Top module: `dvfs_op_ctrl`

## Requirements
- R1: After reset, `clk_sel`, `vreg_code` and `op_point` are 0, and `busy`, `vreg_req` and `wl_error` are low.
- R2: Workloads map to point codes as follows. Users 4 with length 7 or 9, and users 8 with length 7, give 0. Users 8 with length 9, and users 16 with length 7, give 1. Users 16 with length 9 gives 2. Users 32 with length 7 gives 3. Users 32 with length 9 gives 4. Users and length are plain binary values on `wl_users` and `wl_clen`.
- R3: A workload whose user count is not 4, 8, 16 or 32, or whose length is not 7 or 9, is treated as point 4. It sets `wl_error` on the next edge, and `wl_error` stays high until reset.
- R4: A workload that maps to the current `op_point` starts no transition: `busy`, `vreg_req`, `clk_sel` and `vreg_code` do not change.
- R5: On a move to a higher code, `vreg_code` takes the new code and `vreg_req` rises on the same edge. `clk_sel` keeps the old code until the settle interval ends, and then takes the new code.
- R6: On a move to a lower code, `clk_sel` takes the new code first. One edge later, `vreg_code` takes the new code and `vreg_req` rises.
- R7: `vreg_req` stays high until `vreg_ack` is seen high, and it falls on the next edge. `vreg_ack` has no effect while `vreg_req` is low.
- R8: The transition completes exactly SETTLE edges after the edge that sampled the acknowledge. SETTLE must lie in 100..1000, and this is checked at elaboration.
- R9: A workload captured while idle raises `busy` two edges after `wl_valid` is sampled, if it starts a transition. `op_point` takes the new code on the edge that ends the transition, and `busy` falls on that same edge.
- R10: Workloads captured during a transition are held, and a later one replaces an earlier one. Only the last is served, after the running transition completes, including one captured on the completing edge.
- R11: `clk_sel` is never greater than `vreg_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wl_valid | input | 1 | Workload fields are valid this cycle |
| wl_users | input | USER_W | Number of active users |
| wl_clen | input | CLEN_W | Decoder constraint length |
| vreg_ack | input | 1 | Regulator has accepted the requested level |
| vreg_req | output | 1 | Request to the regulator to move to `vreg_code` |
| vreg_code | output | 3 | Voltage level code requested from the regulator |
| clk_sel | output | 3 | Frequency code to the clock generator |
| op_point | output | 3 | Operating point last reached |
| busy | output | 1 | Transition in progress |
| wl_error | output | 1 | Sticky flag: an unsupported workload was seen |

## Verification
Two functions can fall in the same cycle: the end of a settle interval, which commits the point and returns to idle, and the capture of a new workload. The bench waits until its own model shows one cycle of settling left, then drives a workload exactly in that cycle. It judges the result by checking that the held request is served as a fresh transition that starts two edges later and ends at the new point. It also checks that the held request is neither lost nor merged into the finished transition. A stray acknowledge sent while idle is checked for no effect on the select outputs.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int NPT  = 5;
  localparam int PT_W = $clog2(NPT);
  typedef logic [PT_W-1:0] opp_t;
  typedef enum logic [1:0] {ST_IDLE, ST_DROP, ST_WAIT, ST_SETTLE} seq_t;

  function automatic logic wl_ok(input logic [31:0] u, input logic [31:0] k);
    logic u_ok, k_ok;
    u_ok = (u == 32'd4) || (u == 32'd8) || (u == 32'd16) || (u == 32'd32);
    k_ok = (k == 32'd7) || (k == 32'd9);
    return u_ok && k_ok;
  endfunction

  function automatic opp_t wl_point(input logic [31:0] u, input logic [31:0] k);
    logic [1:0] ur;
    logic       kr;
    opp_t       p;
    kr = (k == 32'd9);
    case (u)
      32'd4:   ur = 2'd0;
      32'd8:   ur = 2'd1;
      32'd16:  ur = 2'd2;
      default: ur = 2'd3;
    endcase
    case ({ur, kr})
      3'b000, 3'b001, 3'b010: p = opp_t'(0);
      3'b011, 3'b100:         p = opp_t'(1);
      3'b101:                 p = opp_t'(2);
      3'b110:                 p = opp_t'(3);
      default:                p = opp_t'(4);
    endcase
    if (!wl_ok(u, k)) p = opp_t'(NPT - 1);
    return p;
  endfunction
endpackage

// File: rtl/dvfs_wl_decode.sv
module dvfs_wl_decode
  import dvfs_pkg::*;
#(
  parameter int USER_W = 6,
  parameter int CLEN_W = 4
) (
  input  logic [USER_W-1:0] users,
  input  logic [CLEN_W-1:0] clen,
  output opp_t              point,
  output logic              bad
);
  logic [31:0] u32, k32;
  assign u32   = 32'(users);
  assign k32   = 32'(clen);
  assign point = wl_point(u32, k32);
  assign bad   = !wl_ok(u32, k32);
endmodule

// File: rtl/dvfs_req_hold.sv
module dvfs_req_hold
  import dvfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  opp_t in_point,
  input  logic in_bad,
  input  logic consume,
  output logic pend_vld,
  output opp_t pend_point,
  output logic err_sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld   <= 1'b0;
      pend_point <= '0;
      err_sticky <= 1'b0;
    end else begin
      if (in_valid) begin
        pend_vld   <= 1'b1;
        pend_point <= in_point;
        if (in_bad) err_sticky <= 1'b1;
      end else if (consume) begin
        pend_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dvfs_settle_tmr.sv
module dvfs_settle_tmr #(
  parameter int SETTLE = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  logic [CNT_W-1:0] cnt;
  logic             run;

  assign done = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= CNT_W'(SETTLE - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dvfs_op_ctrl.sv
module dvfs_op_ctrl
  import dvfs_pkg::*;
#(
  parameter int USER_W = 6,
  parameter int CLEN_W = 4,
  parameter int SETTLE = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wl_valid,
  input  logic [USER_W-1:0] wl_users,
  input  logic [CLEN_W-1:0] wl_clen,
  input  logic              vreg_ack,
  output logic              vreg_req,
  output logic [2:0]        vreg_code,
  output logic [2:0]        clk_sel,
  output logic [2:0]        op_point,
  output logic              busy,
  output logic              wl_error
);
  generate
    if (SETTLE < 100 || SETTLE > 1000) begin : g_settle_range
      $error("dvfs_op_ctrl: SETTLE must lie in 100..1000");
    end
  endgenerate

  opp_t dec_point, pend_point, cur_q, tgt_q, clk_q, volt_q;
  logic dec_bad, pend_vld;
  seq_t state;

  // named events, also observed by the bound checker
  logic take_req, start_move, going_down, ack_taken, settle_done;

  assign take_req   = (state == ST_IDLE) && pend_vld;
  assign start_move = take_req && (pend_point != cur_q);
  assign going_down = pend_point < cur_q;
  assign ack_taken  = (state == ST_WAIT) && vreg_ack;

  dvfs_wl_decode #(.USER_W(USER_W), .CLEN_W(CLEN_W)) u_dec (
    .users(wl_users), .clen(wl_clen), .point(dec_point), .bad(dec_bad)
  );

  dvfs_req_hold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(wl_valid), .in_point(dec_point),
    .in_bad(dec_bad), .consume(take_req), .pend_vld(pend_vld),
    .pend_point(pend_point), .err_sticky(wl_error)
  );

  dvfs_settle_tmr #(.SETTLE(SETTLE)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(ack_taken), .done(settle_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cur_q  <= '0;
      tgt_q  <= '0;
      clk_q  <= '0;
      volt_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_move) begin
            tgt_q <= pend_point;
            if (going_down) begin
              clk_q <= pend_point;
              state <= ST_DROP;
            end else begin
              volt_q <= pend_point;
              state  <= ST_WAIT;
            end
          end
        end
        ST_DROP: begin
          volt_q <= tgt_q;
          state  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (vreg_ack) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_done) begin
            clk_q <= tgt_q;
            cur_q <= tgt_q;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign vreg_req  = (state == ST_WAIT);
  assign busy      = (state != ST_IDLE);
  assign vreg_code = 3'(volt_q);
  assign clk_sel   = 3'(clk_q);
  assign op_point  = 3'(cur_q);
endmodule

// File: rtl/dvfs_op_ctrl_chk.sv
module dvfs_op_ctrl_chk #(
  parameter int SETTLE = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vreg_req,
  input logic       vreg_ack,
  input logic [2:0] vreg_code,
  input logic [2:0] clk_sel,
  input logic [2:0] op_point,
  input logic       busy,
  input logic       wl_error,
  input logic       settle_done,
  input logic       take_req
);
  localparam int LIM   = SETTLE + 1;
  localparam int AGE_W = $clog2(LIM + 1);
  logic [AGE_W-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n)                    age <= AGE_W'(LIM);
    else if (vreg_req && vreg_ack) age <= '0;
    else if (age < AGE_W'(LIM))    age <= age + 1'b1;
  end

  a_r11_clk_not_above_volt: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel <= vreg_code);
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_req && !vreg_ack |=> vreg_req);
  a_r7_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_req && vreg_ack |=> !vreg_req);
  a_r5_clk_frozen_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_req |-> clk_sel == $past(clk_sel));
  a_r8_settle_exact: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel > $past(clk_sel) |-> age == AGE_W'(SETTLE));
  a_r9_point_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    op_point != $past(op_point) |-> $past(settle_done) && !busy);
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wl_error |=> wl_error);
  a_r4_busy_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(take_req));
  a_r9_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !vreg_req);
endmodule

bind dvfs_op_ctrl dvfs_op_ctrl_chk #(.SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .vreg_req(vreg_req), .vreg_ack(vreg_ack),
  .vreg_code(vreg_code), .clk_sel(clk_sel), .op_point(op_point),
  .busy(busy), .wl_error(wl_error), .settle_done(settle_done),
  .take_req(take_req)
);

// File: tb/sim_dvfs_op_ctrl.sv
module sim_dvfs_op_ctrl;
  localparam int S = 100;

  logic       clk, rst_n, wl_valid, vreg_ack;
  logic [5:0] wl_users;
  logic [3:0] wl_clen;
  logic       vreg_req, busy, wl_error;
  logic [2:0] vreg_code, clk_sel, op_point;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  dvfs_op_ctrl #(.USER_W(6), .CLEN_W(4), .SETTLE(S)) u0 (
    .clk(clk), .rst_n(rst_n), .wl_valid(wl_valid), .wl_users(wl_users),
    .wl_clen(wl_clen), .vreg_ack(vreg_ack), .vreg_req(vreg_req),
    .vreg_code(vreg_code), .clk_sel(clk_sel), .op_point(op_point),
    .busy(busy), .wl_error(wl_error)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // expected point for a workload, straight from the requirement table
  function automatic int exp_point(int u, int k);
    if (!((u == 4 || u == 8 || u == 16 || u == 32) && (k == 7 || k == 9))) return 4;
    if (u == 32) return (k == 9) ? 4 : 3;
    if (u == 16) return (k == 9) ? 2 : 1;
    if (u == 8)  return (k == 9) ? 1 : 0;
    return 0;
  endfunction

  function automatic bit unsupported(int u, int k);
    return !((u == 4 || u == 8 || u == 16 || u == 32) && (k == 7 || k == 9));
  endfunction

  // behavioural reference model
  int m_cur, m_clk, m_volt, m_phase, m_cnt, m_tgt, m_pend;
  bit m_pend_v, m_err;
  int ack_cyc;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cur = 0; m_clk = 0; m_volt = 0; m_phase = 0; m_cnt = 0;
      m_tgt = 0; m_pend = 0; m_pend_v = 0; m_err = 0;
    end else begin
      if (m_phase == 0) begin
        if (m_pend_v) begin
          m_pend_v = 0;
          if (m_pend != m_cur) begin
            m_tgt = m_pend;
            if (m_pend < m_cur) begin m_clk = m_pend; m_phase = 1; end
            else begin m_volt = m_pend; m_phase = 2; end
          end
        end
      end else if (m_phase == 1) begin
        m_volt = m_tgt; m_phase = 2;
      end else if (m_phase == 2) begin
        if (vreg_ack) begin m_phase = 3; m_cnt = S; ack_cyc = cyc; end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin m_clk = m_tgt; m_cur = m_tgt; m_phase = 0; end
      end
      if (wl_valid) begin
        m_pend_v = 1;
        m_pend = exp_point(int'(wl_users), int'(wl_clen));
        if (unsupported(int'(wl_users), int'(wl_clen))) m_err = 1;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison and ordering monitor
  int  prev_clk = 0;
  bit  busy_seen = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit bad;
      bad = 0;
      if (int'(clk_sel) != m_clk) begin
        $display("FAIL R5 clk_sel actual=%0d expected=%0d", clk_sel, m_clk); bad = 1; end
      if (int'(vreg_code) != m_volt) begin
        $display("FAIL R6 vreg_code actual=%0d expected=%0d", vreg_code, m_volt); bad = 1; end
      if (vreg_req != (m_phase == 2)) begin
        $display("FAIL R7 vreg_req actual=%0d expected=%0d", vreg_req, m_phase == 2); bad = 1; end
      if (busy != (m_phase != 0)) begin
        $display("FAIL R9 busy actual=%0d expected=%0d", busy, m_phase != 0); bad = 1; end
      if (int'(op_point) != m_cur) begin
        $display("FAIL R9 op_point actual=%0d expected=%0d", op_point, m_cur); bad = 1; end
      if (wl_error != m_err) begin
        $display("FAIL R3 wl_error actual=%0d expected=%0d", wl_error, m_err); bad = 1; end
      checks++;
      if (bad) errors++;
      check(clk_sel <= vreg_code, "R11 clk_sel<=vreg_code", clk_sel, vreg_code);
      if (int'(clk_sel) > prev_clk)
        check(cyc - ack_cyc == S, "R8 settle edges", cyc - ack_cyc, S);
      if (int'(clk_sel) < prev_clk)
        check(int'(vreg_code) == prev_clk, "R6 clock drops before voltage",
              vreg_code, prev_clk);
      if (busy) busy_seen = 1;
      prev_clk = int'(clk_sel);
    end
  end

  // regulator model: acknowledges 3 cycles after a request, plus stray pulses
  bit stray_go = 0;
  initial begin
    int wait_n;
    wait_n = 0;
    vreg_ack = 0;
    forever begin
      @(negedge clk);
      if (vreg_ack) vreg_ack = 0;
      else if (stray_go) begin vreg_ack = 1; stray_go = 0; end
      else if (vreg_req && rst_n) begin
        wait_n++;
        if (wait_n == 3) begin vreg_ack = 1; wait_n = 0; end
      end
    end
  end

  task automatic send(int u, int k);
    @(negedge clk);
    wl_valid = 1; wl_users = 6'(u); wl_clen = 4'(k);
    @(negedge clk);
    wl_valid = 0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      if (m_phase == 0 && !m_pend_v) break;
    end
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; wl_valid = 0; wl_users = 0; wl_clen = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(clk_sel == 0 && vreg_code == 0 && op_point == 0, "R1 codes after reset",
          {clk_sel, vreg_code, op_point}, 0);
    check(!busy && !vreg_req && !wl_error, "R1 flags after reset",
          {busy, vreg_req, wl_error}, 0);

    // same point: no transition
    send(4, 7);
    repeat (6) @(negedge clk);
    check(!busy_seen, "R4 no busy for current point", busy_seen, 0);
    check(op_point == 0, "R4 point unchanged", op_point, 0);

    // raise to 2
    send(16, 9);
    @(negedge clk);
    check(busy && vreg_code == 2 && clk_sel == 0, "R5 voltage first on raise",
          {busy, vreg_code, clk_sel}, {1'b1, 3'd2, 3'd0});
    // two more workloads while busy: only the last is served
    send(32, 9);
    send(8, 9);
    wait_idle();
    check(op_point == 1 && clk_sel == 1, "R10 latest held workload served", op_point, 1);

    // unsupported workload
    send(5, 7);
    wait_idle();
    check(op_point == 4, "R3 clamp to top point", op_point, 4);
    check(wl_error, "R3 error flag set", wl_error, 1);
    send(4, 9);
    wait_idle();
    check(op_point == 0 && wl_error, "R3 sticky error and R2 point 0",
          {wl_error, op_point}, {1'b1, 3'd0});

    // stray acknowledge while idle
    stray_go = 1;
    repeat (5) @(negedge clk);
    check(!busy && clk_sel == 0 && vreg_code == 0, "R7 stray ack ignored",
          {busy, clk_sel, vreg_code}, 0);

    // request landing on the completing edge
    send(32, 7);
    forever begin
      @(negedge clk);
      if (m_phase == 3 && m_cnt == 1) break;
    end
    wl_valid = 1; wl_users = 6'd8; wl_clen = 4'd7;
    @(negedge clk);
    wl_valid = 0;
    check(op_point == 3 && !busy, "R9 point reached at completion", op_point, 3);
    @(negedge clk);
    check(busy && clk_sel == 0, "R10 request on completing edge starts new move",
          {busy, clk_sel}, {1'b1, 3'd0});
    wait_idle();
    check(op_point == 0, "R10 completing-edge request served", op_point, 0);

    send(32, 9);
    wait_idle();
    check(op_point == 4, "R2 users 32 length 9", op_point, 4);
    send(16, 7);
    wait_idle();
    check(op_point == 1, "R2 users 16 length 7", op_point, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule